// File: doc/BRIEF.md
# LIN Bus Remote Wake-up Detector

This block watches the digitized LIN bus level while the transceiver sits in a low-power mode. It raises a remote wake-up request only after one specific shape of pulse. That shape is a falling edge, then a dominant level held for at least the dominant filter time, then a rising edge back to recessive. The filter time is nominally 90 µs and is counted in ticks of an external time base. A dominant level that never returns to recessive never wakes the node. A dominant pulse that is too short sends the detector back to waiting for a fresh falling edge.

Before edge detection, the raw bus input passes through a two-stage synchronizer and a three-sample majority filter. A single-cycle glitch therefore cannot start, split or end a pulse. The mode controller drives `arm` high while the device is in a low-power mode. A valid wake produces a one-cycle `wake_strobe`, which the mode controller uses to move from Silent to Fail-safe. It also sets a latched `wake_flag`, which pulls the receive-side indication `rx_wake_n` low to interrupt the host. The flag stays set until Normal mode is entered (`normal_entry`) or reset is applied.

The controller has four states:
- OFF: not armed.
- WAIT_FALL: armed, waiting for a fresh falling edge.
- COUNT: dominant, counting ticks.
- HELD: dominant for the full filter time, waiting for the rising edge.

Its transitions are:
- Any state goes to OFF when `arm` is low.
- OFF goes to WAIT_FALL when `arm` is high.
- WAIT_FALL goes to COUNT on a filtered falling edge.
- COUNT goes to HELD once the tick count reaches `FILTER_TICKS`.
- COUNT goes to WAIT_FALL on a rising edge before that. If the count completes in the same cycle as the rising edge, the pulse counts as a wake.
- HELD goes to WAIT_FALL on a rising edge, and this transition issues the wake.

Top module: `lin_wake_detect`

## Requirements
- R1: After reset, `wake_flag` is 0, `rx_wake_n` is 1 and `wake_strobe` is 0.
- R2: `bus_in` (1 = recessive, 0 = dominant) passes through a two-flop synchronizer and a 3-sample majority filter. A one-cycle change of `bus_in` is ignored and neither starts nor splits a dominant pulse.
- R3: While armed, a wake is issued when three things happen in order: a filtered falling edge, a dominant level lasting at least `FILTER_TICKS` ticks, and a filtered rising edge. The wake is issued on that rising edge.
- R4: A dominant pulse shorter than `FILTER_TICKS` ticks issues no wake and restarts the detector. A following dominant period is timed only from its own fresh falling edge.
- R5: A dominant level of any length issues no wake while it lasts. The wake only comes when the bus returns to recessive.
- R6: While `arm` is 0, bus activity issues no strobe and does not change `wake_flag`.
- R7: A dominant level already present when `arm` rises, including after a disarm in the middle of a pulse, is not timed. A fresh falling edge is required.
- R8: `wake_flag` is set with each wake and holds, whether or not `arm` is high, until `normal_entry` is 1. That clears it on the next clock, and the clear takes priority over a simultaneous set.
- R9: `rx_wake_n` is 0 exactly while `wake_flag` is 1.
- R10: `wake_strobe` is high for exactly one clock cycle per wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Digitized LIN level, 1 = recessive, 0 = dominant |
| arm | input | 1 | High while the device is in a low-power mode |
| normal_entry | input | 1 | High for the cycle Normal mode is entered; clears the flag |
| tick | input | 1 | One-cycle time-base pulse used to time the dominant level |
| wake_strobe | output | 1 | One-cycle remote wake-up request |
| wake_flag | output | 1 | Latched pending-wake flag |
| rx_wake_n | output | 1 | Active-low wake indication toward the receive output |

## Verification
The hardest situation to reach is a dominant level that is already on the bus when the detector becomes armed. If the detector wrongly counted such a level, no sign of it would appear until the later release. The stimulus produces this in two ways. It drives the bus dominant while `arm` is low and then raises `arm`. It also drops `arm` for one cycle in the middle of a dominant pulse. In both cases it holds the bus dominant well past the filter time, releases it, and checks that no wake appears. A clean pulse afterwards must then wake. A dominant pulse split by a one-cycle recessive glitch is used to show that the majority filter joins the two halves into one long pulse.

// File: rtl/wk_pkg.sv
`timescale 1ns/1ps
package wk_pkg;

    typedef enum logic [1:0] {
        WK_OFF       = 2'd0,
        WK_WAIT_FALL = 2'd1,
        WK_COUNT     = 2'd2,
        WK_HELD      = 2'd3
    } wk_state_e;

endpackage

// File: rtl/wk_sync_filter.sv
`timescale 1ns/1ps
module wk_sync_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic [1:0]    hist_q;
    logic          lvl_q;
    logic          lvl_d1_q;
    logic          vote;

    // synchronizer chain, idles recessive
    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[LAST-1:0], raw_in};
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= raw_in;
            end
        end
    endgenerate

    // two of three samples decide the level
    assign vote = (sync_q[LAST] & hist_q[0]) | (sync_q[LAST] & hist_q[1])
                | (hist_q[0] & hist_q[1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q   <= '1;
            lvl_q    <= 1'b1;
            lvl_d1_q <= 1'b1;
        end else begin
            hist_q   <= {hist_q[0], sync_q[LAST]};
            lvl_q    <= vote;
            lvl_d1_q <= lvl_q;
        end
    end

    assign level_o = lvl_q;
    assign rise_o  = lvl_q & ~lvl_d1_q;
    assign fall_o  = ~lvl_q & lvl_d1_q;
endmodule

// File: rtl/wk_dom_timer.sv
`timescale 1ns/1ps
module wk_dom_timer #(
    parameter int FILTER_TICKS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic done_o
);
    localparam int CNT_W = $clog2(FILTER_TICKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FILTER_TICKS);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (clr)                        cnt_q <= '0;
        else if (run && tick && !done_o)     cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = (cnt_q == LIMIT);
endmodule

// File: rtl/wk_fsm.sv
`timescale 1ns/1ps
module wk_fsm
    import wk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic normal_entry,
    input  logic bus_rise,
    input  logic bus_fall,
    input  logic timer_done,
    output logic timer_clr,
    output logic timer_run,
    output logic wake_strobe,
    output logic wake_flag
);
    wk_state_e state_q, state_d;
    logic      wake_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WK_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!arm) begin
            state_d = WK_OFF;
        end else begin
            unique case (state_q)
                WK_OFF:       state_d = WK_WAIT_FALL;
                WK_WAIT_FALL: if (bus_fall) state_d = WK_COUNT;
                WK_COUNT: begin
                    if (bus_rise)        state_d = WK_WAIT_FALL;
                    else if (timer_done) state_d = WK_HELD;
                end
                WK_HELD:      if (bus_rise) state_d = WK_WAIT_FALL;
            endcase
        end
    end

    assign wake_hit  = arm && bus_rise &&
                       ((state_q == WK_HELD) || ((state_q == WK_COUNT) && timer_done));
    assign timer_clr = (state_q == WK_OFF) || (state_q == WK_WAIT_FALL);
    assign timer_run = (state_q == WK_COUNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_strobe <= 1'b0;
            wake_flag   <= 1'b0;
        end else begin
            wake_strobe <= wake_hit;
            if (normal_entry)  wake_flag <= 1'b0;
            else if (wake_hit) wake_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/lin_wake_detect.sv
`timescale 1ns/1ps
module lin_wake_detect #(
    parameter int FILTER_TICKS = 9,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_in,
    input  logic arm,
    input  logic normal_entry,
    input  logic tick,
    output logic wake_strobe,
    output logic wake_flag,
    output logic rx_wake_n
);
    logic lvl, rise, fall;
    logic t_clr, t_run, t_done;

    wk_sync_filter #(.SYNC_STAGES(SYNC_STAGES)) filt_i (
        .clk(clk), .rst_n(rst_n), .raw_in(bus_in),
        .level_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    wk_dom_timer #(.FILTER_TICKS(FILTER_TICKS)) tmr_i (
        .clk(clk), .rst_n(rst_n), .clr(t_clr), .run(t_run),
        .tick(tick), .done_o(t_done)
    );

    wk_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .arm(arm), .normal_entry(normal_entry),
        .bus_rise(rise), .bus_fall(fall), .timer_done(t_done),
        .timer_clr(t_clr), .timer_run(t_run),
        .wake_strobe(wake_strobe), .wake_flag(wake_flag)
    );

    assign rx_wake_n = ~wake_flag;

    logic unused_lvl;
    assign unused_lvl = lvl;
endmodule

// File: rtl/wk_checker.sv
`timescale 1ns/1ps
module wk_checker (
    input logic clk,
    input logic rst_n,
    input logic arm,
    input logic normal_entry,
    input logic wake_strobe,
    input logic wake_flag
);
    a_r10_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_strobe |=> !wake_strobe);

    a_r3_strobe_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wake_strobe |-> wake_flag || $past(normal_entry));

    a_r3_flag_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> wake_strobe);

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        normal_entry |=> !wake_flag);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && !normal_entry) |=> wake_flag);

    a_r6_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> !wake_strobe);
endmodule

bind lin_wake_detect wk_checker chk_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .normal_entry(normal_entry),
    .wake_strobe(wake_strobe), .wake_flag(wake_flag)
);

// File: tb/lin_wake_detect_tb_top.sv
`timescale 1ns/1ps
module lin_wake_detect_tb_top;
    localparam int NV = 7;
    localparam int V_LEN [NV] = '{1, 2, 20, 24, 44, 60, 200};
    localparam bit V_EXP [NV] = '{0, 0, 0, 0, 1, 1, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_in = 1'b1;
    logic arm = 1'b0;
    logic normal_entry = 1'b0;
    logic tick = 1'b0;
    logic wake_strobe, wake_flag, rx_wake_n;

    int n_run = 0;
    int n_fail = 0;
    int strobes = 0;
    int run_len = 0;
    int max_run = 0;
    int tdiv = 0;

    always #2.5 clk = ~clk;

    lin_wake_detect dut_i (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .arm(arm),
        .normal_entry(normal_entry), .tick(tick),
        .wake_strobe(wake_strobe), .wake_flag(wake_flag), .rx_wake_n(rx_wake_n)
    );

    // tick every fourth cycle, driven away from the active edge
    always @(negedge clk) begin
        tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
        tick <= (tdiv == 3);
    end

    always @(negedge clk) begin
        if (rst_n && wake_strobe) begin
            strobes <= strobes + 1;
            run_len <= run_len + 1;
            if (run_len + 1 > max_run) max_run <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_flag();
        normal_entry = 1'b1;
        cyc(1);
        normal_entry = 1'b0;
        cyc(1);
    endtask

    task automatic pulse(input int len);
        bus_in = 1'b0;
        cyc(len);
        bus_in = 1'b1;
        cyc(12);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int base;
        cyc(3);
        chk("R1 flag", wake_flag, 0);
        chk("R1 rx", rx_wake_n, 1);
        chk("R1 strobe", wake_strobe, 0);
        rst_n = 1'b1;
        cyc(4);
        arm = 1'b1;
        cyc(10);

        // vector table: dominant length against expected wake
        for (int v = 0; v < NV; v++) begin
            clear_flag();
            base = strobes;
            pulse(V_LEN[v]);
            chk($sformatf("R3/R4 vec%0d flag", v), wake_flag, V_EXP[v]);
            chk($sformatf("R10 vec%0d strobes", v), strobes - base, V_EXP[v]);
            chk($sformatf("R9 vec%0d rx", v), rx_wake_n, !V_EXP[v]);
        end

        // R5: long dominant only wakes at release
        clear_flag();
        bus_in = 1'b0;
        cyc(200);
        chk("R5 no wake while dominant", wake_flag, 0);
        bus_in = 1'b1;
        cyc(12);
        chk("R5 wake on release", wake_flag, 1);

        // R2: one-cycle recessive glitch inside a dominant pulse is ignored
        clear_flag();
        bus_in = 1'b0; cyc(20);
        bus_in = 1'b1; cyc(1);
        bus_in = 1'b0; cyc(20);
        bus_in = 1'b1; cyc(12);
        chk("R2 glitch joined", wake_flag, 1);

        // R4: real recessive gap restarts timing
        clear_flag();
        bus_in = 1'b0; cyc(20);
        bus_in = 1'b1; cyc(4);
        bus_in = 1'b0; cyc(20);
        bus_in = 1'b1; cyc(12);
        chk("R4 restart", wake_flag, 0);

        // R7: dominant present at arm
        clear_flag();
        arm = 1'b0;
        bus_in = 1'b0; cyc(20);
        arm = 1'b1; cyc(60);
        bus_in = 1'b1; cyc(12);
        chk("R7 pre-arm dominant", wake_flag, 0);
        pulse(48);
        chk("R7 fresh pulse wakes", wake_flag, 1);

        // R7: disarm mid-pulse
        clear_flag();
        bus_in = 1'b0; cyc(20);
        arm = 1'b0; cyc(1);
        arm = 1'b1; cyc(50);
        bus_in = 1'b1; cyc(12);
        chk("R7 rearm mid-pulse", wake_flag, 0);

        // R6: disarmed activity ignored
        clear_flag();
        arm = 1'b0;
        base = strobes;
        pulse(60);
        chk("R6 flag", wake_flag, 0);
        chk("R6 strobes", strobes - base, 0);

        // R8/R9: flag holds across disarm, cleared by normal entry
        arm = 1'b1; cyc(4);
        pulse(60);
        arm = 1'b0;
        cyc(20);
        chk("R8 hold", wake_flag, 1);
        chk("R9 rx low", rx_wake_n, 0);
        normal_entry = 1'b1; cyc(1);
        normal_entry = 1'b0;
        chk("R8 cleared", wake_flag, 0);
        chk("R9 rx high", rx_wake_n, 1);

        chk("R10 strobe width", max_run, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule